// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the combinational hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). From the register indices and write enables of the later stages, it picks the source for each of the two execute-stage ALU operands. Each operand comes either from the register file or from a younger result that has not yet been written back.

The block also drives the pipeline's sequencing controls. These are a hold enable for the program counter and for each pipeline register, plus flush (bubble) controls for the fetch/decode and decode/execute registers. A load in execute whose result is needed by the instruction in decode holds the front end for one cycle and sends a bubble into execute. A taken branch or a jump resolved in execute discards the two younger instructions. While the data cache is serving a miss, the whole pipeline is frozen, and the freeze wins over every other action.

The block holds no state. A hazard that meets a cache freeze is still present in the stage fields when the freeze ends, and it is acted on then.

Top module: `hazard_unit`

## Requirements
- R1: When the memory-stage instruction writes a non-zero destination equal to an execute-stage source register, that operand's select is 2'b10.
- R2: When only the writeback-stage instruction writes a non-zero destination equal to an execute-stage source, that operand's select is 2'b01.
- R3: When the memory-stage and writeback-stage destinations both match the same source, the select is 2'b10.
- R4: Register x0 is never forwarded. A source or destination of x0 gives select 2'b00, even when the write enable is set.
- R5: With no matching write-enabled destination, the select is 2'b00 (register file). A stage whose write enable is low never causes forwarding. No select ever takes the value 2'b11.
- R6: A load in execute with a non-zero destination that equals a source read by the decode instruction clears pcEn and ifIdEn and raises idExFlush. idExEn, exMemEn and memWbEn stay 1, and ifIdFlush stays 0.
- R7: The load-use stall is raised only when the decode instruction actually reads the matching source (its use flag is 1). A load to x0 never stalls, and a non-load producer never stalls.
- R8: exRedirect raises both ifIdFlush and idExFlush with every enable at 1. When it coincides with a load-use match, the redirect outcome is chosen.
- R9: While dcacheBusy is 1, all five enables are 0 and both flush outputs are 0, whatever the other inputs are. Forward selects keep following R1 to R5.
- R10: With no hazard, no redirect and no busy, all enables are 1 and both flushes are 0.
- R11: When dcacheBusy falls while a load-use match or a redirect is still present, the outputs of R6 or R8 appear with no further input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs1 | input | 5 | First source index of the decode instruction |
| idRs2 | input | 5 | Second source index of the decode instruction |
| idUsesRs1 | input | 1 | Decode instruction reads its first source |
| idUsesRs2 | input | 1 | Decode instruction reads its second source |
| exRs1 | input | 5 | First source index in execute |
| exRs2 | input | 5 | Second source index in execute |
| exRd | input | 5 | Destination index in execute |
| exIsLoad | input | 1 | Execute instruction is a load |
| memRd | input | 5 | Destination index in memory stage |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| wbRd | input | 5 | Destination index in writeback stage |
| wbRegWrite | input | 1 | Writeback-stage instruction writes a register |
| exRedirect | input | 1 | Taken branch or jump resolved in execute |
| dcacheBusy | input | 1 | Data cache miss in progress |
| fwdSelA | output | 2 | ALU operand A source: 00 regfile, 10 memory stage, 01 writeback stage |
| fwdSelB | output | 2 | ALU operand B source, same encoding |
| pcEn | output | 1 | Program counter update enable |
| ifIdEn | output | 1 | Fetch/decode register enable |
| idExEn | output | 1 | Decode/execute register enable |
| exMemEn | output | 1 | Execute/memory register enable |
| memWbEn | output | 1 | Memory/writeback register enable |
| ifIdFlush | output | 1 | Clear fetch/decode register |
| idExFlush | output | 1 | Insert bubble into decode/execute register |

## Verification
The bench builds the unit with the default 5-bit register index and two operand sources. That covers the full 32-register space, so both x0 and the highest index x31 can be used as matching and non-matching operands. With two sources, the two operands are tested separately, including one forwarded from memory while the other comes from writeback. The bench also walks the priority chain between the cache freeze, redirect and load-use bubble, and checks the release of a freeze over a pending hazard.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwdSel_e;

  // strobes from the match datapath to the sequencing control
  typedef struct packed {
    logic loadUse;
    logic redirect;
    logic memBusy;
  } hzdStrobe_t;

  typedef struct packed {
    logic pcEn;
    logic ifIdEn;
    logic idExEn;
    logic exMemEn;
    logic memWbEn;
    logic ifIdFlush;
    logic idExFlush;
  } pipeCtl_t;

endpackage

// File: rtl/hazard_match.sv
module hazard_match
  import hzd_pkg::*;
#(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] exRs,
  input  logic [NSRC-1:0][AW-1:0] idRs,
  input  logic [NSRC-1:0]         idUses,
  input  logic [AW-1:0]           exRd,
  input  logic                    exIsLoad,
  input  logic [AW-1:0]           memRd,
  input  logic                    memRegWrite,
  input  logic [AW-1:0]           wbRd,
  input  logic                    wbRegWrite,
  input  logic                    exRedirect,
  input  logic                    dcacheBusy,
  output fwdSel_e [NSRC-1:0]      fwdSel,
  output hzdStrobe_t              strobe
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic memLive, wbLive, loadLive;
  logic [NSRC-1:0] luHit;

  assign memLive  = memRegWrite && (memRd != ZERO_REG);
  assign wbLive   = wbRegWrite  && (wbRd  != ZERO_REG);
  assign loadLive = exIsLoad    && (exRd  != ZERO_REG);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic memHit, wbHit;
    assign memHit = memLive && (memRd == exRs[s]);
    assign wbHit  = wbLive  && (wbRd  == exRs[s]);

    always_comb begin
      if (memHit)     fwdSel[s] = FWD_MEM;
      else if (wbHit) fwdSel[s] = FWD_WB;
      else            fwdSel[s] = FWD_RF;
    end

    assign luHit[s] = loadLive && idUses[s] && (idRs[s] == exRd);
  end

  assign strobe.loadUse  = |luHit;
  assign strobe.redirect = exRedirect;
  assign strobe.memBusy  = dcacheBusy;

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hzd_pkg::*;
(
  input  hzdStrobe_t strobe,
  output pipeCtl_t   ctl
);

  always_comb begin
    ctl = '{pcEn: 1'b1, ifIdEn: 1'b1, idExEn: 1'b1, exMemEn: 1'b1,
            memWbEn: 1'b1, ifIdFlush: 1'b0, idExFlush: 1'b0};
    if (strobe.memBusy) begin
      ctl.pcEn    = 1'b0;
      ctl.ifIdEn  = 1'b0;
      ctl.idExEn  = 1'b0;
      ctl.exMemEn = 1'b0;
      ctl.memWbEn = 1'b0;
    end else if (strobe.redirect) begin
      ctl.ifIdFlush = 1'b1;
      ctl.idExFlush = 1'b1;
    end else if (strobe.loadUse) begin
      ctl.pcEn      = 1'b0;
      ctl.ifIdEn    = 1'b0;
      ctl.idExFlush = 1'b1;
    end
  end

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] idRs1,
  input  logic [AW-1:0] idRs2,
  input  logic          idUsesRs1,
  input  logic          idUsesRs2,
  input  logic [AW-1:0] exRs1,
  input  logic [AW-1:0] exRs2,
  input  logic [AW-1:0] exRd,
  input  logic          exIsLoad,
  input  logic [AW-1:0] memRd,
  input  logic          memRegWrite,
  input  logic [AW-1:0] wbRd,
  input  logic          wbRegWrite,
  input  logic          exRedirect,
  input  logic          dcacheBusy,
  output logic [1:0]    fwdSelA,
  output logic [1:0]    fwdSelB,
  output logic          pcEn,
  output logic          ifIdEn,
  output logic          idExEn,
  output logic          exMemEn,
  output logic          memWbEn,
  output logic          ifIdFlush,
  output logic          idExFlush
);

  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] exRsV, idRsV;
  logic [NSRC-1:0]         idUsesV;
  fwdSel_e [NSRC-1:0]      fwdSelV;
  hzdStrobe_t              strobe;
  pipeCtl_t                ctl;

  assign exRsV   = {exRs2, exRs1};
  assign idRsV   = {idRs2, idRs1};
  assign idUsesV = {idUsesRs2, idUsesRs1};

  hazard_match #(.AW(AW), .NSRC(NSRC)) u_match (
    .exRs(exRsV), .idRs(idRsV), .idUses(idUsesV),
    .exRd(exRd), .exIsLoad(exIsLoad),
    .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .exRedirect(exRedirect), .dcacheBusy(dcacheBusy),
    .fwdSel(fwdSelV), .strobe(strobe)
  );

  hazard_ctrl u_ctrl (.strobe(strobe), .ctl(ctl));

  assign fwdSelA   = fwdSelV[0];
  assign fwdSelB   = fwdSelV[1];
  assign pcEn      = ctl.pcEn;
  assign ifIdEn    = ctl.ifIdEn;
  assign idExEn    = ctl.idExEn;
  assign exMemEn   = ctl.exMemEn;
  assign memWbEn   = ctl.memWbEn;
  assign ifIdFlush = ctl.ifIdFlush;
  assign idExFlush = ctl.idExFlush;

endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] exRs1,
  input logic [AW-1:0] exRs2,
  input logic [AW-1:0] memRd,
  input logic          memRegWrite,
  input logic          exRedirect,
  input logic          dcacheBusy,
  input logic [1:0]    fwdSelA,
  input logic [1:0]    fwdSelB,
  input logic          pcEn,
  input logic          ifIdEn,
  input logic          idExEn,
  input logic          exMemEn,
  input logic          memWbEn,
  input logic          ifIdFlush,
  input logic          idExFlush
);

  always_comb begin
    // R9
    busy_freeze_chk: assert (!dcacheBusy ||
      ({pcEn, ifIdEn, idExEn, exMemEn, memWbEn, ifIdFlush, idExFlush} == 7'b0));
    // R4
    zero_src_chk: assert ((exRs1 != '0 || fwdSelA == 2'b00) &&
                          (exRs2 != '0 || fwdSelB == 2'b00));
    // R1
    mem_fwd_chk: assert (!(memRegWrite && memRd != '0 && memRd == exRs1) ||
                         fwdSelA == 2'b10);
    // R5
    fwd_code_chk: assert (fwdSelA != 2'b11 && fwdSelB != 2'b11);
    // R6
    bubble_pair_chk: assert (dcacheBusy || pcEn || (idExFlush && !ifIdEn && idExEn));
    // R8
    redirect_flush_chk: assert (dcacheBusy || !exRedirect ||
                                (ifIdFlush && idExFlush && pcEn));
  end

endmodule

bind hazard_unit hazard_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/hazard_unit_test.sv
module hazard_unit_test;

  typedef struct packed {
    logic [4:0] idRs1, idRs2;
    logic       idUsesRs1, idUsesRs2;
    logic [4:0] exRs1, exRs2, exRd;
    logic       exIsLoad;
    logic [4:0] memRd;
    logic       memRegWrite;
    logic [4:0] wbRd;
    logic       wbRegWrite;
    logic       exRedirect, dcacheBusy;
  } stim_t;

  typedef struct {
    logic [1:0] fa, fb;
    logic [4:0] en;   // pc, ifId, idEx, exMem, memWb
    logic [1:0] fl;   // ifIdFlush, idExFlush
    string      req;
  } exp_t;

  logic clk = 0;
  always #2.5 clk = ~clk;

  stim_t st = '0;
  logic [1:0] fwdSelA, fwdSelB;
  logic pcEn, ifIdEn, idExEn, exMemEn, memWbEn, ifIdFlush, idExFlush;

  hazard_unit uut (
    .idRs1(st.idRs1), .idRs2(st.idRs2), .idUsesRs1(st.idUsesRs1), .idUsesRs2(st.idUsesRs2),
    .exRs1(st.exRs1), .exRs2(st.exRs2), .exRd(st.exRd), .exIsLoad(st.exIsLoad),
    .memRd(st.memRd), .memRegWrite(st.memRegWrite), .wbRd(st.wbRd), .wbRegWrite(st.wbRegWrite),
    .exRedirect(st.exRedirect), .dcacheBusy(st.dcacheBusy),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB), .pcEn(pcEn), .ifIdEn(ifIdEn), .idExEn(idExEn),
    .exMemEn(exMemEn), .memWbEn(memWbEn), .ifIdFlush(ifIdFlush), .idExFlush(idExFlush)
  );

  exp_t q[$];
  int checks = 0, fails = 0;
  logic done = 0;

  localparam logic [4:0] ALL_EN = 5'b11111;
  localparam logic [4:0] LU_EN  = 5'b00111;

  task automatic cmp(input string what, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: apply stimulus shortly after the rising edge, queue expectation
  task automatic drive(input stim_t s, input logic [1:0] fa, input logic [1:0] fb,
                       input logic [4:0] en, input logic [1:0] fl, input string req);
    exp_t e;
    @(posedge clk);
    #0.5;
    st = s;
    e.fa = fa; e.fb = fb; e.en = en; e.fl = fl; e.req = req;
    q.push_back(e);
  endtask

  // monitor: sample at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp("fwdSelA", e.req, {6'b0, fwdSelA}, {6'b0, e.fa});
      cmp("fwdSelB", e.req, {6'b0, fwdSelB}, {6'b0, e.fb});
      cmp("enables", e.req, {3'b0, pcEn, ifIdEn, idExEn, exMemEn, memWbEn}, {3'b0, e.en});
      cmp("flushes", e.req, {6'b0, ifIdFlush, idExFlush}, {6'b0, e.fl});
    end
  end

  initial begin
    stim_t s;
    // R10 idle, all zero
    s = '0;
    drive(s, 2'b00, 2'b00, ALL_EN, 2'b00, "R10");
    // R1 mem forward on A
    s = '0; s.exRs1 = 5'd3; s.exRs2 = 5'd4; s.memRd = 5'd3; s.memRegWrite = 1;
    drive(s, 2'b10, 2'b00, ALL_EN, 2'b00, "R1");
    // R2 wb forward on B, mem forward on A
    s.wbRd = 5'd4; s.wbRegWrite = 1;
    drive(s, 2'b10, 2'b01, ALL_EN, 2'b00, "R2");
    // R3 both match same source x31
    s = '0; s.exRs1 = 5'd31; s.exRs2 = 5'd31; s.memRd = 5'd31; s.memRegWrite = 1;
    s.wbRd = 5'd31; s.wbRegWrite = 1;
    drive(s, 2'b10, 2'b10, ALL_EN, 2'b00, "R3");
    // R4 x0 never forwarded
    s = '0; s.memRegWrite = 1; s.wbRegWrite = 1;
    drive(s, 2'b00, 2'b00, ALL_EN, 2'b00, "R4");
    // R5 write enables low
    s = '0; s.exRs1 = 5'd7; s.exRs2 = 5'd7; s.memRd = 5'd7; s.wbRd = 5'd7;
    drive(s, 2'b00, 2'b00, ALL_EN, 2'b00, "R5");
    // R6 load-use on rs2
    s = '0; s.exIsLoad = 1; s.exRd = 5'd9; s.idRs2 = 5'd9; s.idUsesRs2 = 1; s.idRs1 = 5'd2; s.idUsesRs1 = 1;
    drive(s, 2'b00, 2'b00, LU_EN, 2'b01, "R6");
    // R7 matching index but not read
    s.idUsesRs2 = 0;
    drive(s, 2'b00, 2'b00, ALL_EN, 2'b00, "R7");
    // R7 load to x0
    s = '0; s.exIsLoad = 1; s.idUsesRs1 = 1; s.idUsesRs2 = 1;
    drive(s, 2'b00, 2'b00, ALL_EN, 2'b00, "R7");
    // R7 non-load producer
    s = '0; s.exRd = 5'd5; s.idRs1 = 5'd5; s.idUsesRs1 = 1;
    drive(s, 2'b00, 2'b00, ALL_EN, 2'b00, "R7");
    // R8 redirect
    s = '0; s.exRedirect = 1;
    drive(s, 2'b00, 2'b00, ALL_EN, 2'b11, "R8");
    // R8 redirect with load-use match
    s.exIsLoad = 1; s.exRd = 5'd6; s.idRs1 = 5'd6; s.idUsesRs1 = 1;
    drive(s, 2'b00, 2'b00, ALL_EN, 2'b11, "R8");
    // R9 busy over load-use, forwarding still live
    s = '0; s.dcacheBusy = 1; s.exIsLoad = 1; s.exRd = 5'd6; s.idRs1 = 5'd6; s.idUsesRs1 = 1;
    s.exRs2 = 5'd8; s.wbRd = 5'd8; s.wbRegWrite = 1;
    drive(s, 2'b00, 2'b01, 5'b00000, 2'b00, "R9");
    // R11 release -> load-use outcome
    s.dcacheBusy = 0;
    drive(s, 2'b00, 2'b01, LU_EN, 2'b01, "R11");
    // R9 busy over redirect
    s = '0; s.dcacheBusy = 1; s.exRedirect = 1;
    drive(s, 2'b00, 2'b00, 5'b00000, 2'b00, "R9");
    // R11 release -> redirect outcome
    s.dcacheBusy = 0;
    drive(s, 2'b00, 2'b00, ALL_EN, 2'b11, "R11");
    // R10 back to idle
    s = '0;
    drive(s, 2'b00, 2'b00, ALL_EN, 2'b00, "R10");
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule